// File: doc/BRIEF.md
# Buffered Serial Baud Rate Generator

This block produces the timing pulses for an asynchronous serial port. It divides the bus clock by a 13-bit programmable divisor to give a single-cycle oversampling pulse for the receiver sampler. It divides that pulse by sixteen again to give a single-cycle bit pulse for the transmitter. Software reaches the block through two byte-wide registers. The upper register holds two interrupt-enable bits and the top five divisor bits. The lower register holds the bottom eight divisor bits.

A divisor is written in two steps. The upper byte is held in a private buffer. Writing the lower byte then commits all thirteen bits in one clock. Because of this, the generator never runs with a half-updated divisor. A commit restarts both counters, so the first pulse after it already follows the new period. The generator is gated off when the divisor is zero or when neither the receiver enable nor the transmitter enable is set. While it is gated off, its counters stay at zero. The lower register resets to a non-zero divisor, but the generator still waits for an enable after reset.

Top module: `sbaud_divider`

## Requirements
- R1: After reset the upper register (wr_addr/rd_addr = 0) reads 0x00, the lower register (address 1) reads 0x04, and both interrupt-enable outputs are 0.
- R2: A write to the upper register places data bits 4:0 in a buffer only. Until the next lower-register write, the upper register reads back the committed divisor bits 12:8 and the pulse period is unchanged.
- R3: While the committed divisor is 0, neither tick16 nor bit_tick ever pulses.
- R4: With divisor BR from 1 to 8191 and the generator running, tick16 is a one-cycle pulse every BR clocks. After a commit on a clock edge, the first tick16 is in the BR-th cycle following that edge.
- R5: Upper-register bit 7 drives brk_ie and bit 6 drives edge_ie. Both take their value from the clock edge of the write, with no buffering. Bit 5 always reads 0.
- R6: bit_tick pulses only together with tick16, on every 16th tick16, so its period is 16×BR clocks.
- R7: The generator runs only while the divisor is non-zero and rx_en or tx_en is 1. Otherwise both counters are held at zero. After an enable rises, the first tick16 falls BR-1 cycles after the cycle in which the enable first reads 1, and the first bit_tick falls 16×BR-1 cycles after it.
- R8: A lower-register write commits {buffer, data} as the 13-bit divisor and resets the oversampling and bit counters. The first bit_tick after the commit is in the 16×BR-th cycle following the commit edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_addr | input | 1 | Write target: 0 = upper register, 1 = lower register |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read select: 0 = upper register, 1 = lower register |
| rd_data | output | 8 | Combinational read data |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| tick16 | output | 1 | One-cycle oversampling pulse |
| bit_tick | output | 1 | One-cycle bit pulse, every 16th tick16 |
| brk_ie | output | 1 | Break-detect interrupt enable |
| edge_ie | output | 1 | Input-active-edge interrupt enable |

## Verification
The assertions assume that wr_en, wr_addr and wr_data are synchronous to clk and valid at each rising edge. They also assume that one write strobe targets a single register, so a buffer load and a commit never occur in the same cycle. The stimulus changes every input only just after a falling edge or one nanosecond after a rising edge. It holds each write strobe for exactly one rising edge. It reads the outputs at falling edges, half a period away from any register update.

// File: rtl/sbaud_pkg.sv
package sbaud_pkg;
  typedef enum logic {
    REG_UPPER = 1'b0,
    REG_LOWER = 1'b1
  } sbaud_reg_e;
endpackage

// File: rtl/sbaud_regs.sv
module sbaud_regs
  import sbaud_pkg::*;
#(
  parameter int DIV_W  = 13,
  parameter int DATA_W = 8,
  parameter int LO_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DIV_W-1:0]  div_o,
  output logic              commit_o,
  output logic              brk_ie_o,
  output logic              edge_ie_o
);
  localparam int HI_W  = DIV_W - DATA_W;
  localparam int PAD_W = DATA_W - 2 - HI_W;

  logic [HI_W-1:0]  shadow_q;
  logic [DIV_W-1:0] div_q;
  logic             brk_q, edge_q;
  logic             wr_upper;

  assign wr_upper = wr_en && (wr_addr == REG_UPPER);
  assign commit_o = wr_en && (wr_addr == REG_LOWER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      div_q    <= DIV_W'(LO_RST);
      brk_q    <= 1'b0;
      edge_q   <= 1'b0;
    end else begin
      if (wr_upper) begin
        shadow_q <= wr_data[HI_W-1:0];
        brk_q    <= wr_data[DATA_W-1];
        edge_q   <= wr_data[DATA_W-2];
      end
      if (commit_o) begin
        div_q <= {shadow_q, wr_data};
      end
    end
  end

  always_comb begin
    if (rd_addr == REG_UPPER) begin
      rd_data = {brk_q, edge_q, {PAD_W{1'b0}}, div_q[DIV_W-1:DATA_W]};
    end else begin
      rd_data = div_q[DATA_W-1:0];
    end
  end

  assign div_o     = div_q;
  assign brk_ie_o  = brk_q;
  assign edge_ie_o = edge_q;

  // R2: an upper write alone leaves the working divisor untouched
  a_r2_upper_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    wr_upper |=> $stable(div_q));
endmodule

// File: rtl/sbaud_prescale.sv
module sbaud_prescale #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             commit_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick16_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end   = (cnt_q == div_i - 1'b1);
  assign tick16_o = run_i && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || commit_i || at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: while running the counter stays below the divisor
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < div_i));
  // R4: each pulse restarts the period from zero
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick16_o |=> (cnt_q == '0));
endmodule

// File: rtl/sbaud_x16.sv
module sbaud_x16 #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic commit_i,
  input  logic tick16_i,
  output logic bit_tick_o
);
  localparam int OVS_W = $clog2(OVS);

  logic [OVS_W-1:0] cnt_q;
  logic             last;

  assign last       = (cnt_q == OVS_W'(OVS - 1));
  assign bit_tick_o = tick16_i && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || commit_i) begin
      cnt_q <= '0;
    end else if (tick16_i) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  // R6: a bit pulse never appears without an oversampling pulse
  a_r6_sub_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick_o |-> tick16_i);
  // R7: a stopped generator holds the count at zero
  a_r7_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/sbaud_divider.sv
module sbaud_divider #(
  parameter int DIV_W  = 13,
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int LO_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_en,
  input  logic              tx_en,
  output logic              tick16,
  output logic              bit_tick,
  output logic              brk_ie,
  output logic              edge_ie
);
  logic [DIV_W-1:0] div;
  logic             commit;
  logic             run;

  sbaud_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W), .LO_RST(LO_RST)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .div_o(div), .commit_o(commit), .brk_ie_o(brk_ie), .edge_ie_o(edge_ie)
  );

  assign run = (div != '0) && (rx_en || tx_en);

  sbaud_prescale #(.DIV_W(DIV_W)) i_prescale (
    .clk(clk), .rst_n(rst_n), .run_i(run), .commit_i(commit),
    .div_i(div), .tick16_o(tick16)
  );

  sbaud_x16 #(.OVS(OVS)) i_x16 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .commit_i(commit),
    .tick16_i(tick16), .bit_tick_o(bit_tick)
  );

  // R3: a zero divisor keeps both outputs quiet
  a_r3_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |-> (!tick16 && !bit_tick));
endmodule

// File: tb/test_sbaud_divider.sv
`timescale 1ns/1ps
module test_sbaud_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       rx_en = 1'b0;
  logic       tx_en = 1'b0;
  logic       tick16, bit_tick, brk_ie, edge_ie;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  sbaud_divider i_sbaud_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rx_en(rx_en), .tx_en(tx_en), .tick16(tick16), .bit_tick(bit_tick),
    .brk_ie(brk_ie), .edge_ie(edge_ie)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic addr, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic addr, output int val);
    rd_addr = addr;
    #0.1 val = int'(rd_data);
  endtask

  // index (from 1) of the first falling-edge sample showing the pulse, 0 if none
  task automatic wait_pulse(input bit use_bit, input int limit, output int idx);
    idx = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (use_bit ? bit_tick : tick16) begin
        idx = i;
        break;
      end
    end
  endtask

  task automatic t_reset;
    int v;
    reg_read(1'b0, v); check("R1 upper reset", v, 8'h00);
    reg_read(1'b1, v); check("R1 lower reset", v, 8'h04);
    check("R1 brk_ie reset", int'(brk_ie), 0);
    check("R1 edge_ie reset", int'(edge_ie), 0);
  endtask

  task automatic t_enable_start;
    int idx;
    wait_pulse(1'b0, 40, idx); check("R7 idle before enable", idx, 0);
    rx_en = 1'b1;
    wait_pulse(1'b0, 20, idx); check("R7 first tick16 after enable", idx, 3);
    wait_pulse(1'b0, 20, idx); check("R4 tick16 spacing BR=4", idx, 4);
    wait_pulse(1'b1, 100, idx); check("R6 first bit_tick after enable", idx, 56);
    check("R6 bit_tick with tick16", int'(tick16), 1);
  endtask

  task automatic t_period(input int br);
    int idx;
    reg_write(1'b0, 8'((br >> 8) & 8'h1F));
    reg_write(1'b1, 8'(br & 8'hFF));
    wait_pulse(1'b0, br + 5, idx); check("R8 first tick16 after commit", idx, br);
    wait_pulse(1'b0, br + 5, idx); check("R4 tick16 period", idx, br);
    wait_pulse(1'b1, 16 * br, idx); check("R8 first bit_tick after commit", idx, 14 * br);
    wait_pulse(1'b1, 17 * br, idx); check("R6 bit_tick period", idx, 16 * br);
  endtask

  task automatic t_upper_buffer;
    int v, idx;
    reg_write(1'b0, 8'h00);
    reg_read(1'b0, v); check("R2 upper reads committed", v, 8'h01);
    wait_pulse(1'b0, 400, idx);
    wait_pulse(1'b0, 400, idx); check("R2 period unchanged", idx, 300);
    reg_write(1'b1, 8'h05);
    reg_read(1'b0, v); check("R2 upper after commit", v, 8'h00);
    wait_pulse(1'b0, 20, idx); check("R2 new period applies", idx, 5);
  endtask

  task automatic t_zero;
    int v, idx;
    reg_write(1'b0, 8'h00);
    reg_write(1'b1, 8'h00);
    reg_read(1'b1, v); check("R3 lower reads zero", v, 0);
    wait_pulse(1'b0, 100, idx); check("R3 no tick16", idx, 0);
    wait_pulse(1'b1, 100, idx); check("R3 no bit_tick", idx, 0);
  endtask

  task automatic t_ie_bits;
    int v;
    reg_write(1'b0, 8'hFF);
    check("R5 brk_ie set", int'(brk_ie), 1);
    check("R5 edge_ie set", int'(edge_ie), 1);
    reg_read(1'b0, v); check("R5 bit5 zero, buffered bits hidden", v, 8'hC0);
    reg_write(1'b1, 8'h02);
    reg_read(1'b0, v); check("R5 upper after commit", v, 8'hDF);
    reg_read(1'b1, v); check("R8 lower after commit", v, 8'h02);
    reg_write(1'b0, 8'h40);
    check("R5 brk_ie cleared", int'(brk_ie), 0);
    check("R5 edge_ie kept", int'(edge_ie), 1);
    reg_write(1'b1, 8'h06);
  endtask

  task automatic t_disable;
    int idx;
    @(negedge clk);
    rx_en = 1'b0; tx_en = 1'b0;
    wait_pulse(1'b0, 50, idx); check("R7 stopped without enable", idx, 0);
    tx_en = 1'b1;
    wait_pulse(1'b0, 20, idx); check("R7 restart from zero", idx, 5);
    wait_pulse(1'b1, 200, idx); check("R7 first bit_tick on restart", idx, 90);
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #20 rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_enable_start;
    t_period(7);
    t_period(300);
    t_upper_buffer;
    t_zero;
    t_ie_bits;
    t_disable;
    t_period(1);
    done = 1'b1;
    report;
  end

  initial begin
    #500000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report;
    end
  end
endmodule